// File: doc/BRIEF.md
# SPI flash command engine

This block is a memory-mapped SPI master that runs one serial-flash command per request. Software programs an opcode byte and a combined count byte, which carries a receive count in its upper half and a transmit count in its lower half. It then pushes the transmit payload through a single data port into an eight-entry byte store and starts the engine with a self-clearing go bit. The engine drops chip select, sends the opcode and then the stored transmit bytes, and then clocks in the requested number of reply bytes. The opcode never passes through the store.

One store serves both directions. Reply bytes land in the entries that follow the transmit bytes, and the index wraps modulo eight. To collect a reply, software rewinds the access pointer, reads past its own transmit bytes, and then reads the reply. The engine keeps its own byte index, which starts at entry 0, so the position of the software pointer at launch does not matter. The serial side uses SPI mode 0 with the most significant bit first. SCK runs at the system clock divided by an even parameter.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset the pointer reads 0, the go bit reads 0, spi_cs_n is 1, and spi_sck and spi_mosi are 0.
- R2: A write to offset 0xC stores the byte at the pointer and advances it. A read from offset 0xC returns the byte at the pointer and advances it. The pointer wraps from 7 to 0.
- R3: Writing a byte to offset 0x2 with bit 4 set returns the pointer to 0. Offset 0xD reads the pointer in bits 2:0 with the upper bits 0, and reading it does not move the pointer.
- R4: Offset 0x1 holds the counts: bits 3:0 are the transmit byte count and bits 7:4 are the receive byte count. Each count is limited to 8 when it is used.
- R5: Writing offset 0x2 with bit 0 set while idle starts a command. Bit 0 of offset 0x2 reads 1 from the next cycle until the frame ends and then reads 0 without any further write.
- R6: A frame is the opcode, then the transmit bytes taken from entries 0, 1 and onward, then the receive bytes, all sent MSB first while spi_cs_n stays low. It has exactly 8*(1+tx+rx) SCK rising edges.
- R7: Receive byte r is stored at entry (tx+r) mod 8, and the entries below it are left as they were.
- R8: SCK idles low. MOSI changes only while SCK is low, and MISO is sampled on the SCK rising edge. The SCK period is CLK_DIV system clocks.
- R9: spi_cs_n rises exactly CLK_DIV system clocks after the last SCK falling edge of the frame, and it is high whenever the engine is idle.
- R10: While a command runs, writes to offsets 0x0, 0x1 and 0xC have no effect on the registers, the stored bytes or the pointer.
- R11: Offsets 0x0 and 0x1 read back the last byte accepted into them, including count values above 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash device |
| spi_miso | input | 1 | Serial data from the flash device |

## Verification
The bench runs every combination of transmit and receive counts from 0 to 8, plus counts above 8 that must be limited. Against a model store it checks the serial frame and the full contents of the store afterwards. A design that indexed reply bytes from the software pointer, or that failed to wrap at eight, would corrupt entries that the model predicts unchanged. A design with an off-by-one in the byte sequencer would produce the wrong number of SCK edges or lose the last reply byte. The bench also probes writes made while a command runs, the wrap of the data port and the gap between the last SCK edge and chip select release. A design that let those writes through, or that released chip select early, would show a changed readback or a wrong clock count.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
    localparam int FIFO_DEPTH = 8;
    localparam int PTR_W      = $clog2(FIFO_DEPTH);
    localparam int CNT_W      = PTR_W + 1;
    localparam int ADDR_W     = 4;

    localparam logic [ADDR_W-1:0] OFS_OPCODE = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 4'h1;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'h2;
    localparam logic [ADDR_W-1:0] OFS_DATA   = 4'hC;
    localparam logic [ADDR_W-1:0] OFS_PTR    = 4'hD;

    localparam int GO_BIT     = 0;
    localparam int REWIND_BIT = 4;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_SHIFT = 2'd1,
        SH_TAIL  = 2'd2
    } sh_state_e;

    // limit a 4-bit count field to the store depth
    function automatic logic [CNT_W-1:0] limit_cnt(input logic [3:0] raw);
        if (raw > 4'(FIFO_DEPTH)) return CNT_W'(FIFO_DEPTH);
        return CNT_W'(raw);
    endfunction
endpackage

// File: rtl/spi_eng_fifo.sv
module spi_eng_fifo
    import spi_eng_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [PTR_W-1:0] ridx_a,
    output logic [7:0]       rdata_a,
    input  logic [PTR_W-1:0] ridx_b,
    output logic [7:0]       rdata_b
);
    logic [FIFO_DEPTH-1:0][7:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int i = 0; i < FIFO_DEPTH; i++) begin
            if (we && widx == PTR_W'(i)) mem_d[i] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rdata_a = mem_q[ridx_a];
    assign rdata_b = mem_q[ridx_b];
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter
    import spi_eng_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       opcode,
    input  logic [CNT_W-1:0] tx_n,
    input  logic [CNT_W-1:0] rx_n,
    output logic [PTR_W-1:0] fetch_idx,
    input  logic [7:0]       fetch_data,
    output logic             store_we,
    output logic [PTR_W-1:0] store_idx,
    output logic [7:0]       store_data,
    output logic             busy,
    output logic             sck,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso
);
    localparam int DIV_W = $clog2(CLK_DIV) + 1;
    localparam int TOT_W = CNT_W + 2;
    localparam logic [DIV_W-1:0] HALF_M1 = DIV_W'(CLK_DIV / 2 - 1);
    localparam logic [DIV_W-1:0] FULL_M1 = DIV_W'(CLK_DIV - 1);

    typedef struct packed {
        sh_state_e        st;
        logic [DIV_W-1:0] div;
        logic             sck;
        logic             cs_n;
        logic [2:0]       bitn;
        logic [TOT_W-1:0] byten;
        logic [7:0]       tx_sr;
        logic [7:0]       rx_sr;
    } sh_t;

    sh_t q, d;
    logic [TOT_W-1:0] tx_ext, last_byte;

    assign tx_ext    = TOT_W'(tx_n);
    assign last_byte = TOT_W'(tx_n) + TOT_W'(rx_n);

    always_comb begin
        d          = q;
        store_we   = 1'b0;
        fetch_idx  = q.byten[PTR_W-1:0];
        store_idx  = q.byten[PTR_W-1:0] - PTR_W'(1);
        store_data = q.rx_sr;
        unique case (q.st)
            SH_IDLE: begin
                if (start) begin
                    d.st    = SH_SHIFT;
                    d.cs_n  = 1'b0;
                    d.sck   = 1'b0;
                    d.div   = '0;
                    d.bitn  = '0;
                    d.byten = '0;
                    d.tx_sr = opcode;
                end
            end
            SH_SHIFT: begin
                if (q.div == HALF_M1) begin
                    d.div = '0;
                    if (!q.sck) begin
                        d.sck   = 1'b1;
                        d.rx_sr = {q.rx_sr[6:0], miso};
                    end else begin
                        d.sck = 1'b0;
                        if (q.bitn == 3'd7) begin
                            store_we = (q.byten > tx_ext);
                            if (q.byten == last_byte) begin
                                d.st    = SH_TAIL;
                                d.tx_sr = '0;
                            end else begin
                                d.byten = q.byten + TOT_W'(1);
                                d.bitn  = '0;
                                d.tx_sr = (q.byten < tx_ext) ? fetch_data : 8'h00;
                            end
                        end else begin
                            d.bitn  = q.bitn + 3'd1;
                            d.tx_sr = {q.tx_sr[6:0], 1'b0};
                        end
                    end
                end else begin
                    d.div = q.div + DIV_W'(1);
                end
            end
            SH_TAIL: begin
                if (q.div == FULL_M1) begin
                    d.st   = SH_IDLE;
                    d.cs_n = 1'b1;
                    d.div  = '0;
                end else begin
                    d.div = q.div + DIV_W'(1);
                end
            end
            default: d.st = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy = (q.st != SH_IDLE);
    assign sck  = q.sck;
    assign cs_n = q.cs_n;
    assign mosi = q.tx_sr[7];

    AST_CS_HIGH_IDLE:  assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n);               // R9
    AST_SCK_IDLE_LOW:  assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);                // R8
    AST_MOSI_AT_RISE:  assert property (@(posedge clk) disable iff (!rst_n) $rose(sck) |-> $stable(mosi)); // R8
    AST_STORE_IN_RX:   assert property (@(posedge clk) disable iff (!rst_n) store_we |-> busy && !cs_n);   // R7
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_eng_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    typedef struct packed {
        logic [7:0]       opcode;
        logic [7:0]       count;
        logic [PTR_W-1:0] ptr;
    } regs_t;

    regs_t q, d;

    logic             busy, start, sw_data_wr, sw_data_rd, rewind;
    logic             eng_we, fifo_we;
    logic [PTR_W-1:0] eng_widx, eng_ridx, fifo_widx;
    logic [7:0]       eng_wdata, eng_rdata, fifo_wdata, port_rdata;
    logic [CNT_W-1:0] tx_n, rx_n;

    always_comb begin
        d          = q;
        sw_data_wr = bus_wr && bus_addr == OFS_DATA && !busy;
        sw_data_rd = bus_rd && bus_addr == OFS_DATA;
        rewind     = bus_wr && bus_addr == OFS_CTRL && bus_wdata[REWIND_BIT];
        start      = bus_wr && bus_addr == OFS_CTRL && bus_wdata[GO_BIT] && !busy;
        if (bus_wr && !busy && bus_addr == OFS_OPCODE) d.opcode = bus_wdata;
        if (bus_wr && !busy && bus_addr == OFS_COUNT)  d.count  = bus_wdata;
        if (rewind)                          d.ptr = '0;
        else if (sw_data_wr || sw_data_rd)   d.ptr = q.ptr + PTR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_n       = limit_cnt(q.count[3:0]);
    assign rx_n       = limit_cnt(q.count[7:4]);
    assign fifo_we    = eng_we || sw_data_wr;
    assign fifo_widx  = eng_we ? eng_widx  : q.ptr;
    assign fifo_wdata = eng_we ? eng_wdata : bus_wdata;

    always_comb begin
        unique case (bus_addr)
            OFS_OPCODE: bus_rdata = q.opcode;
            OFS_COUNT:  bus_rdata = q.count;
            OFS_CTRL:   bus_rdata = {7'b0, busy};
            OFS_DATA:   bus_rdata = port_rdata;
            OFS_PTR:    bus_rdata = 8'(q.ptr);
            default:    bus_rdata = 8'h00;
        endcase
    end

    spi_eng_fifo u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (fifo_we),
        .widx    (fifo_widx),
        .wdata   (fifo_wdata),
        .ridx_a  (q.ptr),
        .rdata_a (port_rdata),
        .ridx_b  (eng_ridx),
        .rdata_b (eng_rdata)
    );

    spi_eng_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .opcode     (q.opcode),
        .tx_n       (tx_n),
        .rx_n       (rx_n),
        .fetch_idx  (eng_ridx),
        .fetch_data (eng_rdata),
        .store_we   (eng_we),
        .store_idx  (eng_widx),
        .store_data (eng_wdata),
        .busy       (busy),
        .sck        (spi_sck),
        .cs_n       (spi_cs_n),
        .mosi       (spi_mosi),
        .miso       (spi_miso)
    );

    AST_REWIND_ZERO:   assert property (@(posedge clk) disable iff (!rst_n) rewind |=> q.ptr == '0);                                 // R3
    AST_GO_SETS_BUSY:  assert property (@(posedge clk) disable iff (!rst_n) start |=> busy);                                          // R5
    AST_OPCODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) busy && bus_wr && bus_addr == OFS_OPCODE |=> $stable(q.opcode)); // R10
    AST_COUNT_LOCKED:  assert property (@(posedge clk) disable iff (!rst_n) busy && bus_wr && bus_addr == OFS_COUNT |=> $stable(q.count));   // R10
    AST_ONE_WRITER:    assert property (@(posedge clk) disable iff (!rst_n) !(eng_we && sw_data_wr));                                 // R10
endmodule

// File: tb/tb_spi_cmd_engine.sv
module tb_spi_cmd_engine;
    localparam int CLK_DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       spi_sck, spi_cs_n, spi_mosi, spi_miso;

    always #5 clk = ~clk;

    spi_cmd_engine #(.CLK_DIV(CLK_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0, fails = 0, cyc = 0;
    logic [7:0] model [8];

    // slave model state, each variable written by one process
    int rise_tot = 0, rise_base = 0, fall_tot = 0, fall_base = 0;
    int last_rise = 0, last_fall = 0, cs_rise = 0, per_err = 0;
    logic [7:0] sh = '0;
    logic [7:0] cap [32];

    function automatic logic [7:0] resp(int j);
        return 8'(j * 29 + 75);
    endfunction

    function automatic logic miso_bit(int n);
        logic [7:0] b;
        b = resp(n / 8);
        return b[7 - (n % 8)];
    endfunction

    assign spi_miso = miso_bit(fall_tot - fall_base);

    always @(negedge clk) cyc <= cyc + 1;

    always @(negedge spi_cs_n) begin
        rise_base = rise_tot;
        fall_base = fall_tot;
    end
    always @(posedge spi_cs_n) cs_rise = cyc;
    always @(negedge spi_sck) begin
        fall_tot  = fall_tot + 1;
        last_fall = cyc;
    end
    always @(posedge spi_sck) begin
        if (rise_tot != rise_base && cyc - last_rise != CLK_DIV) per_err = per_err + 1;
        last_rise = cyc;
        sh        = {sh[6:0], spi_mosi};
        rise_tot  = rise_tot + 1;
        if ((rise_tot - rise_base) % 8 == 0 && (rise_tot - rise_base) / 8 <= 32)
            cap[(rise_tot - rise_base) / 8 - 1] = sh;
    end

    task automatic chk(input logic ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle(output logic ok);
        logic [7:0] v;
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            rd(4'h2, v);
            if (v[0] == 1'b0) begin ok = 1'b1; break; end
        end
    endtask

    task automatic run(input logic [7:0] op, input logic [3:0] traw, input logic [3:0] rraw, input logic probe);
        int tx, rx, r0;
        logic [7:0] v;
        logic ok;
        tx = (traw > 8) ? 8 : int'(traw);
        rx = (rraw > 8) ? 8 : int'(rraw);
        wr(4'h0, op);
        wr(4'h1, {rraw, traw});
        wr(4'h2, 8'h10);
        for (int k = 0; k < tx; k++) begin
            wr(4'hC, op ^ 8'(k * 17 + 3));
            model[k] = op ^ 8'(k * 17 + 3);
        end
        wr(4'h2, 8'h10);
        rd(4'hD, v);
        chk(v == 8'h00, "R3", "pointer after rewind", int'(v), 0);
        r0 = rise_tot;
        wr(4'h2, 8'h01);
        rd(4'h2, v);
        chk(v[0] == 1'b1, "R5", "go bit while running", int'(v[0]), 1);
        if (probe) begin
            wr(4'h0, ~op);
            wr(4'h1, 8'h00);
            wr(4'hC, 8'hEE);
        end
        wait_idle(ok);
        chk(ok, "R5", "go bit self-clear", int'(ok), 1);
        chk(rise_tot - r0 == 8 * (1 + tx + rx), "R6", "SCK rising edges", rise_tot - r0, 8 * (1 + tx + rx));
        chk(cap[0] == op, "R6", "opcode on MOSI", int'(cap[0]), int'(op));
        for (int k = 0; k < tx; k++)
            chk(cap[1 + k] == model[k], "R6", "tx byte on MOSI", int'(cap[1 + k]), int'(model[k]));
        chk(per_err == 0, "R8", "SCK period errors", per_err, 0);
        chk(cs_rise - last_fall == CLK_DIV, "R9", "CS release delay", cs_rise - last_fall, CLK_DIV);
        for (int r = 0; r < rx; r++) model[(tx + r) % 8] = resp(1 + tx + r);
        wr(4'h2, 8'h10);
        for (int k = 0; k < 8; k++) begin
            rd(4'hC, v);
            chk(v == model[k], "R7", "store entry after frame", int'(v), int'(model[k]));
        end
        rd(4'hD, v);
        chk(v == 8'h00, "R2", "pointer wrapped after 8 reads", int'(v), 0);
        if (probe) begin
            rd(4'h0, v);
            chk(v == op, "R10", "opcode kept while running", int'(v), int'(op));
            rd(4'h1, v);
            chk(v == {rraw, traw}, "R10", "count kept while running", int'(v), int'({rraw, traw}));
        end
    endtask

    initial begin
        logic [7:0] v;
        for (int k = 0; k < 8; k++) model[k] = 8'h00;
        for (int k = 0; k < 32; k++) cap[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(spi_cs_n == 1'b1, "R1", "cs_n after reset", int'(spi_cs_n), 1);
        chk(spi_sck == 1'b0 && spi_mosi == 1'b0, "R1", "sck/mosi after reset", int'({spi_sck, spi_mosi}), 0);
        rd(4'hD, v);
        chk(v == 8'h00, "R1", "pointer after reset", int'(v), 0);
        rd(4'h2, v);
        chk(v == 8'h00, "R1", "go bit after reset", int'(v), 0);
        // R11 readback including raw counts above 8
        wr(4'h0, 8'h9F);
        rd(4'h0, v);
        chk(v == 8'h9F, "R11", "opcode readback", int'(v), 8'h9F);
        wr(4'h1, 8'hFB);
        rd(4'h1, v);
        chk(v == 8'hFB, "R11", "count readback", int'(v), 8'hFB);
        // R2 data port writes wrap modulo 8
        wr(4'h2, 8'h10);
        for (int k = 0; k < 10; k++) begin
            wr(4'hC, 8'(8'hC0 + k));
            model[k % 8] = 8'(8'hC0 + k);
        end
        rd(4'hD, v);
        chk(v == 8'h02, "R2", "pointer after 10 writes", int'(v), 2);
        rd(4'hD, v);
        chk(v == 8'h02, "R3", "pointer read does not move it", int'(v), 2);
        wr(4'h2, 8'h10);
        for (int k = 0; k < 8; k++) begin
            rd(4'hC, v);
            chk(v == model[k], "R2", "data port readback", int'(v), int'(model[k]));
        end
        // R6 R7 sweep all counts
        for (int t = 0; t <= 8; t++)
            for (int r = 0; r <= 8; r++)
                run(8'(8'h03 + t * 9 + r), 4'(t), 4'(r), 1'b0);
        // R4 limiting of oversized counts
        run(8'h0B, 4'hF, 4'hF, 1'b0);
        run(8'h5A, 4'h9, 4'hC, 1'b0);
        run(8'hAB, 4'h3, 4'hA, 1'b0);
        // R10 writes while running
        run(8'h9F, 4'h2, 4'h3, 1'b1);
        run(8'h05, 4'h0, 4'h1, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(negedge clk) begin
        if (cyc > 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule